// File: doc/BRIEF.md
# Instruction Issue and Skip Sequencer

This block sits between an instruction fetch port and the decoder. Every cycle that is not stalled and has a valid fetch, it takes one 24-bit program word. The opcode is in bits 23:16 and the operand is in bits 15:0. For each word it decides one of three outcomes. The word can be issued as a real instruction. It can be held as the first half of a two-word instruction and later joined with its extension word into a 48-bit instruction. Or it can be replaced by a NOP bubble. A parameter list of opcodes marks which first words start a two-word instruction.

Execute reports two events, each applying to the word consumed next: a taken conditional skip and a taken flow change. A taken skip puts bubbles in place of the skipped instruction: one bubble for a one-word instruction, two for a two-word one. The skipping instruction therefore costs two or three cycles in total. A flow change flushes exactly one slot. An extension word that turns up on its own decodes as a NOP. Every output slot reports how far the program counter moved for the word it consumed.

Top module: `seq_issue_top`

## Requirements
- R1: While reset is asserted, and until the first valid fetch after reset, issue_valid, long_valid and nop_insert are 0, pc_advance is 0 and every data output is 0.
- R2: In the normal state, with no skip or flow change in effect, a consumed word whose opcode (bits 23:16) is non-zero and not in the two-word list is issued one cycle later. Issuing sets issue_valid=1, issue_opcode=bits 23:16, issue_operand=bits 15:0 and pc_advance=2.
- R3: A consumed word whose opcode is in the two-word list produces an empty slot with pc_advance=2. The next consumed word is taken as its extension. That slot has issue_valid=1, long_valid=1, long_insn={first word, extension word} and opcode/operand taken from the first word.
- R4: In the normal state, a consumed word with opcode 8'h00 and no skip or flow change in effect gives nop_insert=1 and issue_valid=0.
- R5: A taken skip applied to a one-word instruction replaces it with exactly one NOP slot. The next word decodes normally.
- R6: A taken skip applied to a word that starts a two-word instruction replaces both that word and the following word with NOP slots.
- R7: A taken flow change replaces the next consumed word with exactly one NOP slot, even if it starts a two-word instruction. The word after it decodes normally.
- R8: When a skip and a flow change are both in effect for the same word, the flow change wins: only one slot is flushed.
- R9: A skip or flow change raised in the normal state while no word is consumed and no stall is active is held pending and applies to the next consumed word.
- R10: While stall is high, every output holds its value, no word is consumed, and skip and flow-change inputs are ignored.
- R11: Skip and flow-change inputs have no effect while an extension word or a second skipped word is awaited.
- R12: A non-stalled cycle without a valid fetch gives issue_valid=0, long_valid=0, nop_insert=0 and pc_advance=0.
- R13: Only opcodes in the parameter list start a two-word instruction. With the default list (8'h02, 8'h04, 8'h07, 8'hBE), opcode 8'h03 is issued as a one-word instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word | input | 24 | Fetched program word |
| fetch_valid | input | 1 | fetch_word is valid this cycle |
| skip_taken | input | 1 | Execute took a conditional skip |
| branch_taken | input | 1 | Execute redirected the program counter |
| stall | input | 1 | Freeze all state and outputs |
| issue_valid | output | 1 | An instruction is issued this slot |
| issue_opcode | output | 8 | Opcode of the issued instruction |
| issue_operand | output | 16 | Operand bits of the issued instruction |
| long_valid | output | 1 | The issued instruction is a two-word one |
| long_insn | output | 48 | Assembled two-word instruction |
| nop_insert | output | 1 | This slot is a NOP bubble |
| pc_advance | output | 4 | Address units consumed by this slot |

## Verification
A taken skip and a taken flow change can apply to the same fetched word, either as two raw inputs in the same cycle or as one pending and one raw. The bench drives this directly: the two events together on a word that starts a two-word instruction, and one of them latched during an empty fetch cycle while the other arrives with the word. Random stimulus also makes these collisions often. The bench reference model flushes only one slot in that case. A design that also squashed the extension word would show an extra NOP where the model expects a normal issue.

// File: rtl/seq_issue_pkg.sv
package seq_issue_pkg;

    // Slot tracking: what the next consumed word means.
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,  // next word is a fresh instruction
        MODE_EXT     = 2'd1,  // next word completes a two-word instruction
        MODE_SKIPEXT = 2'd2   // next word is the tail of a skipped two-word instruction
    } seq_mode_e;

endpackage

// File: rtl/seq_longop_lut.sv
module seq_longop_lut #(
    parameter int                        OPC_W    = 8,
    parameter int                        NUM_LONG = 4,
    parameter logic [NUM_LONG*OPC_W-1:0] LONG_OPS = {8'hBE, 8'h07, 8'h04, 8'h02}
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             is_long
);

    logic [NUM_LONG-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_LONG; g++) begin : g_cmp
            assign hit[g] = (opcode == LONG_OPS[g*OPC_W +: OPC_W]);
        end
    endgenerate

    assign is_long = |hit;

endmodule

// File: rtl/seq_issue_fsm.sv
module seq_issue_fsm
    import seq_issue_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int OPC_W   = 8,
    parameter int ADV_W   = 4,
    parameter int PC_STEP = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         fetch_word,
    input  logic                      fetch_valid,
    input  logic                      skip_taken,
    input  logic                      branch_taken,
    input  logic                      stall,
    input  logic                      word_is_long,
    output logic                      issue_valid,
    output logic [OPC_W-1:0]          issue_opcode,
    output logic [WORD_W-OPC_W-1:0]   issue_operand,
    output logic                      long_valid,
    output logic [2*WORD_W-1:0]       long_insn,
    output logic                      nop_insert,
    output logic [ADV_W-1:0]          pc_advance
);

    localparam int OPR_W = WORD_W - OPC_W;
    localparam logic [ADV_W-1:0] STEP = ADV_W'(PC_STEP);

    typedef struct packed {
        seq_mode_e           mode;
        logic                pend_skip;
        logic                pend_branch;
        logic [WORD_W-1:0]   first_word;
        logic                issue_valid;
        logic [OPC_W-1:0]    opcode;
        logic [OPR_W-1:0]    operand;
        logic                long_valid;
        logic [2*WORD_W-1:0] long_insn;
        logic                nop_insert;
        logic [ADV_W-1:0]    pc_adv;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             take;
    logic             skip_eff;
    logic             branch_eff;
    logic [OPC_W-1:0] word_opc;

    assign word_opc   = fetch_word[WORD_W-1 -: OPC_W];
    assign take       = fetch_valid && !stall;
    assign skip_eff   = skip_taken || st_q.pend_skip;
    assign branch_eff = branch_taken || st_q.pend_branch;

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d.issue_valid = 1'b0;
            st_d.long_valid  = 1'b0;
            st_d.nop_insert  = 1'b0;
            st_d.pc_adv      = '0;
            unique case (st_q.mode)
                MODE_NORMAL: begin
                    if (take) begin
                        st_d.pc_adv      = STEP;
                        st_d.pend_skip   = 1'b0;
                        st_d.pend_branch = 1'b0;
                        if (branch_eff) begin
                            // flow change: flush exactly one slot
                            st_d.nop_insert = 1'b1;
                        end else if (skip_eff) begin
                            st_d.nop_insert = 1'b1;
                            if (word_is_long) begin
                                st_d.mode = MODE_SKIPEXT;
                            end
                        end else if (word_is_long) begin
                            st_d.first_word = fetch_word;
                            st_d.mode       = MODE_EXT;
                        end else if (word_opc == '0) begin
                            // lone extension word behaves as a NOP
                            st_d.nop_insert = 1'b1;
                        end else begin
                            st_d.issue_valid = 1'b1;
                            st_d.opcode      = word_opc;
                            st_d.operand     = fetch_word[OPR_W-1:0];
                        end
                    end else begin
                        st_d.pend_skip   = st_q.pend_skip || skip_taken;
                        st_d.pend_branch = st_q.pend_branch || branch_taken;
                    end
                end
                MODE_EXT: begin
                    if (take) begin
                        st_d.pc_adv      = STEP;
                        st_d.issue_valid = 1'b1;
                        st_d.long_valid  = 1'b1;
                        st_d.opcode      = st_q.first_word[WORD_W-1 -: OPC_W];
                        st_d.operand     = st_q.first_word[OPR_W-1:0];
                        st_d.long_insn   = {st_q.first_word, fetch_word};
                        st_d.mode        = MODE_NORMAL;
                    end
                end
                MODE_SKIPEXT: begin
                    if (take) begin
                        st_d.pc_adv     = STEP;
                        st_d.nop_insert = 1'b1;
                        st_d.mode       = MODE_NORMAL;
                    end
                end
                default: begin
                    st_d.mode = MODE_NORMAL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MODE_NORMAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid   = st_q.issue_valid;
    assign issue_opcode  = st_q.opcode;
    assign issue_operand = st_q.operand;
    assign long_valid    = st_q.long_valid;
    assign long_insn     = st_q.long_insn;
    assign nop_insert    = st_q.nop_insert;
    assign pc_advance    = st_q.pc_adv;

endmodule

// File: rtl/seq_issue_top.sv
module seq_issue_top #(
    parameter int                        WORD_W   = 24,
    parameter int                        OPC_W    = 8,
    parameter int                        ADV_W    = 4,
    parameter int                        PC_STEP  = 2,
    parameter int                        NUM_LONG = 4,
    parameter logic [NUM_LONG*OPC_W-1:0] LONG_OPS = {8'hBE, 8'h07, 8'h04, 8'h02}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WORD_W-1:0]         fetch_word,
    input  logic                      fetch_valid,
    input  logic                      skip_taken,
    input  logic                      branch_taken,
    input  logic                      stall,
    output logic                      issue_valid,
    output logic [OPC_W-1:0]          issue_opcode,
    output logic [WORD_W-OPC_W-1:0]   issue_operand,
    output logic                      long_valid,
    output logic [2*WORD_W-1:0]       long_insn,
    output logic                      nop_insert,
    output logic [ADV_W-1:0]          pc_advance
);

    logic word_is_long;

    seq_longop_lut #(
        .OPC_W    (OPC_W),
        .NUM_LONG (NUM_LONG),
        .LONG_OPS (LONG_OPS)
    ) lut_i (
        .opcode  (fetch_word[WORD_W-1 -: OPC_W]),
        .is_long (word_is_long)
    );

    seq_issue_fsm #(
        .WORD_W  (WORD_W),
        .OPC_W   (OPC_W),
        .ADV_W   (ADV_W),
        .PC_STEP (PC_STEP)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_word    (fetch_word),
        .fetch_valid   (fetch_valid),
        .skip_taken    (skip_taken),
        .branch_taken  (branch_taken),
        .stall         (stall),
        .word_is_long  (word_is_long),
        .issue_valid   (issue_valid),
        .issue_opcode  (issue_opcode),
        .issue_operand (issue_operand),
        .long_valid    (long_valid),
        .long_insn     (long_insn),
        .nop_insert    (nop_insert),
        .pc_advance    (pc_advance)
    );

endmodule

// File: rtl/seq_issue_checker.sv
module seq_issue_checker #(
    parameter int WORD_W  = 24,
    parameter int OPC_W   = 8,
    parameter int ADV_W   = 4,
    parameter int PC_STEP = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fetch_valid,
    input logic                    stall,
    input logic                    issue_valid,
    input logic [OPC_W-1:0]        issue_opcode,
    input logic [WORD_W-OPC_W-1:0] issue_operand,
    input logic                    long_valid,
    input logic [2*WORD_W-1:0]     long_insn,
    input logic                    nop_insert,
    input logic [ADV_W-1:0]        pc_advance
);

    // R4/R5: a slot is never both a bubble and a real issue
    p_issue_or_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && nop_insert));

    // R3: a two-word result is always an issued instruction
    p_long_is_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        long_valid |-> issue_valid);

    // R10: stall holds every output
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(issue_valid) && $stable(issue_opcode) && $stable(issue_operand)
                   && $stable(long_valid) && $stable(long_insn) && $stable(nop_insert)
                   && $stable(pc_advance)));

    // R12: no fetch and no stall gives an empty slot
    p_empty_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !fetch_valid) |=> (!issue_valid && !long_valid && !nop_insert && pc_advance == '0));

    // R2: every consumed word advances the program counter by one step
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && fetch_valid) |=> (pc_advance == ADV_W'(PC_STEP)));

    // R1: outputs are cleared while reset is asserted
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (!issue_valid && !long_valid && !nop_insert && pc_advance == '0);
        end
    end

endmodule

bind seq_issue_top seq_issue_checker #(
    .WORD_W  (WORD_W),
    .OPC_W   (OPC_W),
    .ADV_W   (ADV_W),
    .PC_STEP (PC_STEP)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .stall         (stall),
    .issue_valid   (issue_valid),
    .issue_opcode  (issue_opcode),
    .issue_operand (issue_operand),
    .long_valid    (long_valid),
    .long_insn     (long_insn),
    .nop_insert    (nop_insert),
    .pc_advance    (pc_advance)
);

// File: tb/seq_issue_top_tb_top.sv
`timescale 1ns/1ps
module seq_issue_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] fetch_word = '0;
    logic        fetch_valid = 1'b0;
    logic        skip_taken = 1'b0;
    logic        branch_taken = 1'b0;
    logic        stall = 1'b0;
    logic        issue_valid;
    logic [7:0]  issue_opcode;
    logic [15:0] issue_operand;
    logic        long_valid;
    logic [47:0] long_insn;
    logic        nop_insert;
    logic [3:0]  pc_advance;

    always #2.5 clk = ~clk;

    seq_issue_top dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_valid(fetch_valid),
        .skip_taken(skip_taken), .branch_taken(branch_taken), .stall(stall),
        .issue_valid(issue_valid), .issue_opcode(issue_opcode), .issue_operand(issue_operand),
        .long_valid(long_valid), .long_insn(long_insn), .nop_insert(nop_insert),
        .pc_advance(pc_advance)
    );

    int errors = 0;
    int checks = 0;

    // reference model state: 0 normal, 1 awaiting extension, 2 awaiting skipped tail
    int          m_mode = 0;
    logic        m_pskip = 0, m_pbr = 0;
    logic [23:0] m_first = '0;
    logic        e_iv = 0, e_lv = 0, e_nop = 0;
    logic [7:0]  e_opc = '0;
    logic [15:0] e_opr = '0;
    logic [47:0] e_long = '0;
    logic [3:0]  e_adv = '0;
    string       e_tag = "R1";

    function automatic logic is_long_op(input logic [7:0] op);
        return (op == 8'h02) || (op == 8'h04) || (op == 8'h07) || (op == 8'hBE);
    endfunction

    task automatic check_outputs();
        checks++;
        if (issue_valid !== e_iv || long_valid !== e_lv || nop_insert !== e_nop ||
            issue_opcode !== e_opc || issue_operand !== e_opr || long_insn !== e_long ||
            pc_advance !== e_adv) begin
            errors++;
            $display("FAIL %s: got iv=%0b lv=%0b nop=%0b opc=%h opr=%h long=%h adv=%0d exp iv=%0b lv=%0b nop=%0b opc=%h opr=%h long=%h adv=%0d",
                     e_tag, issue_valid, long_valid, nop_insert, issue_opcode, issue_operand,
                     long_insn, pc_advance, e_iv, e_lv, e_nop, e_opc, e_opr, e_long, e_adv);
        end
    endtask

    // advance the reference model by one clock with the given inputs
    task automatic model(input logic [23:0] w, input logic fv, input logic sk,
                         input logic br, input logic st, input string force_tag);
        logic sk_e, br_e, tk;
        string t;
        tk = fv && !st;
        sk_e = sk || m_pskip;
        br_e = br || m_pbr;
        if (st) begin
            t = "R10";
        end else begin
            e_iv = 0; e_lv = 0; e_nop = 0; e_adv = 0;
            t = "R12";
            if (m_mode == 0) begin
                if (tk) begin
                    e_adv = 4'd2;
                    if (m_pskip || m_pbr) t = "R9";
                    if (br_e) begin
                        e_nop = 1; if (sk_e) t = "R8"; else if (!m_pbr) t = "R7";
                    end else if (sk_e) begin
                        e_nop = 1;
                        if (is_long_op(w[23:16])) begin m_mode = 2; if (!m_pskip) t = "R6"; end
                        else if (!m_pskip) t = "R5";
                    end else if (is_long_op(w[23:16])) begin
                        m_first = w; m_mode = 1; t = "R3";
                    end else if (w[23:16] == 8'h00) begin
                        e_nop = 1; t = "R4";
                    end else begin
                        e_iv = 1; e_opc = w[23:16]; e_opr = w[15:0]; t = "R2";
                    end
                    m_pskip = 0; m_pbr = 0;
                end else begin
                    if (sk || br) t = "R9";
                    m_pskip = m_pskip || sk;
                    m_pbr = m_pbr || br;
                end
            end else if (tk) begin
                e_adv = 4'd2;
                if (m_mode == 1) begin
                    e_iv = 1; e_lv = 1; e_opc = m_first[23:16]; e_opr = m_first[15:0];
                    e_long = {m_first, w}; t = "R3";
                end else begin
                    e_nop = 1; t = "R6";
                end
                if (sk || br) t = "R11";
                m_mode = 0;
            end else if (sk || br) begin
                t = "R11";
            end
        end
        e_tag = (force_tag != "") ? force_tag : t;
    endtask

    task automatic step(input logic [23:0] w, input logic fv, input logic sk,
                        input logic br, input logic st, input string force_tag);
        @(negedge clk);
        check_outputs();
        fetch_word = w; fetch_valid = fv; skip_taken = sk; branch_taken = br; stall = st;
        model(w, fv, sk, br, st, force_tag);
    endtask

    function automatic logic [23:0] rand_word();
        int r;
        logic [7:0] op;
        r = $urandom_range(0, 99);
        if (r < 20) begin
            case ($urandom_range(0, 3))
                0: op = 8'h02; 1: op = 8'h04; 2: op = 8'h07; default: op = 8'hBE;
            endcase
        end else if (r < 30) begin
            op = 8'h00;
        end else begin
            op = 8'($urandom_range(1, 255));
        end
        return {op, 16'($urandom())};
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        process::self().srandom(32'd1234);
        e_tag = "R1";
        repeat (3) @(negedge clk);
        check_outputs();                                  // R1 during reset
        rst_n = 1'b1;
        step(24'h000000, 0, 0, 0, 0, "R1");               // R1 nothing before first fetch
        step(24'h000000, 0, 0, 0, 0, "R1");
        step(24'h15ABCD, 1, 0, 0, 0, "");                 // R2 one-word issue
        step(24'h03BEEF, 1, 0, 0, 0, "R13");              // R13 opcode not in list
        step(24'h041111, 1, 0, 0, 0, "");                 // R3 first word
        step(24'h002222, 1, 0, 0, 0, "");                 // R3 extension
        step(24'h003333, 1, 0, 0, 0, "");                 // R4 stray extension
        step(24'h224444, 1, 1, 0, 0, "");                 // R5 skip one-word
        step(24'h235555, 1, 0, 0, 0, "");
        step(24'hBE6666, 1, 1, 0, 0, "");                 // R6 skip two-word
        step(24'h007777, 1, 0, 0, 0, "");
        step(24'h318888, 1, 0, 0, 0, "");
        step(24'h079999, 1, 0, 1, 0, "");                 // R7 flush a long first word
        step(24'h00AAAA, 1, 0, 0, 0, "");                 // R4 following word normal
        step(24'h02BBBB, 1, 1, 1, 0, "");                 // R8 both on long word
        step(24'h40CCCC, 1, 0, 0, 0, "");                 // not squashed
        step(24'h000000, 0, 1, 0, 0, "");                 // R9 latch skip
        step(24'h41DDDD, 1, 0, 0, 0, "");                 // R9 applied
        step(24'h000000, 0, 0, 1, 0, "");                 // R9 latch branch
        step(24'h02EEEE, 1, 1, 0, 0, "");                 // R8 pending branch + raw skip
        step(24'h42FFFF, 1, 0, 0, 0, "");
        step(24'h431234, 1, 1, 1, 1, "");                 // R10 stall ignores all
        step(24'h441234, 1, 0, 0, 1, "");
        step(24'h455678, 1, 0, 0, 0, "");                 // R10 follow-up: normal issue
        step(24'h07AAAA, 1, 0, 0, 0, "");                 // R3 start
        step(24'h000000, 0, 1, 1, 0, "");                 // R11 ignored while waiting
        step(24'h00BBBB, 1, 1, 1, 0, "");                 // R11 ext with events
        step(24'h46CCCC, 1, 0, 0, 0, "");                 // no leftover skip
        step(24'h000000, 0, 0, 0, 0, "");                 // R12 empty slot
        for (int i = 0; i < 4000; i++) begin
            step(rand_word(), ($urandom_range(0, 99) < 80), ($urandom_range(0, 99) < 15),
                 ($urandom_range(0, 99) < 10), ($urandom_range(0, 99) < 10), "");
        end
        step(24'h000000, 0, 0, 0, 0, "");
        @(negedge clk);
        check_outputs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule